// File: doc/BRIEF.md
# Byte-Parity Storage Check Unit

This unit guards a processor's storage and I/O data paths with parity. When software writes storage, the unit adds one parity bit to each byte of the data word. When storage is read, it checks every byte and its parity bit. It applies the same odd-parity rule to an 8-bit I/O data path. The inbound side of that path is active-high. The outbound side is active-low, so the unit inverts outbound data and parity at the pins. A request that names a device address outside the populated range also counts as a fault.

Any fault sets a latched process-check condition, which lights an indicator output and halts the processor. A static strap input can mask the halt so that diagnostics keep running. While the halt is masked, the fault is still recorded and the indicator still lights. Three sticky status bits show which kind of fault occurred: storage parity, I/O parity or bad device address. A test harness can read them. The status bits and the indicator stay set until reset or until a one-cycle clear pulse.

Top module: `pchk_unit`

## Requirements
- R1: The storage write bus carries the data word in bits [15:0], the low-byte parity in bit 16 and the high-byte parity in bit 17. Each parity bit makes the count of ones in its byte plus the parity bit odd.
- R2: When `st_rd_valid` is high, a read byte whose 8 data bits plus its parity bit hold an even number of ones sets `sts_st_par` on the next clock edge. An all-zero byte with a zero parity bit is such an error.
- R3: When `st_rd_valid` or `io_in_valid` is low, the data on the matching bus has no effect on any status bit.
- R4: When `io_in_valid` is high and `io_in_data` plus `io_in_par` hold an even number of ones, `sts_io_par` is set on the next edge.
- R5: The outbound pins carry the inverse of `io_out_src`. `io_out_par_n` carries the inverse of that byte's odd-parity bit.
- R6: When `dev_req` is high and `dev_addr` is at or above DEV_LIMIT (default 12), `sts_bad_addr` is set on the next edge. Addresses below the limit, or any address while `dev_req` is low, set nothing.
- R7: `check_lamp` is set on the edge after any fault and always equals the OR of the three status bits.
- R8: `halt` is high exactly when `check_lamp` is high and `halt_dis` is low. With `halt_dis` high, faults are still recorded.
- R9: The status bits and `check_lamp` stay set until reset, or until the edge on which `err_clr` is high, which clears them all.
- R10: A fault detected in the same cycle as `err_clr` wins: its status bit and `check_lamp` are set after that edge.
- R11: After reset, every status bit, `check_lamp` and `halt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_wr_data | input | 16 | Storage write data |
| st_wr_bus | output | 18 | Write data with per-byte parity |
| st_rd_valid | input | 1 | Storage read bus holds valid data |
| st_rd_bus | input | 18 | Storage read data with parity |
| io_in_valid | input | 1 | Inbound I/O byte valid |
| io_in_data | input | 8 | Inbound I/O byte, active-high |
| io_in_par | input | 1 | Inbound I/O parity |
| io_out_src | input | 8 | Outbound I/O byte from the datapath |
| io_out_pins_n | output | 8 | Outbound I/O byte, active-low |
| io_out_par_n | output | 1 | Outbound parity, active-low |
| dev_req | input | 1 | Device access request |
| dev_addr | input | 4 | Requested device address |
| halt_dis | input | 1 | Static strap that masks the halt |
| err_clr | input | 1 | Clears all fault state |
| halt | output | 1 | Processor halt request |
| check_lamp | output | 1 | Process-check indicator |
| sts_st_par | output | 1 | Sticky storage parity fault |
| sts_io_par | output | 1 | Sticky I/O parity fault |
| sts_bad_addr | output | 1 | Sticky bad device address fault |

## Verification
The checker watches every cycle for several rules. It confirms that the write bus and the outbound pins always carry odd parity. Each detected fault must set its own status bit one edge later. The indicator must stay equal to the OR of the status bits, and the halt must follow the indicator and the strap. It also checks that fault state survives until a clear, and that a fault wins when it coincides with a clear. Some behaviour only the directed scenarios can show. These include exact write-bus bit positions for chosen data patterns and the all-zero byte corner. They also include the address boundary at the limit, and the absence of any effect from invalid strobes or an idle request. The reset state is shown only by the scenarios too.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    localparam int BYTE_W = 8;

    // Latched fault state; lamp is kept as its own flop
    typedef struct packed {
        logic lamp;
        logic bad_addr;
        logic io_par;
        logic st_par;
    } fault_t;

    // Bit that gives a byte an odd count of ones
    function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/pchk_parity_gen.sv
module pchk_parity_gen
    import pchk_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int NB = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [NB-1:0]     par
);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign par[g] = odd_bit(data[g*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/pchk_parity_chk.sv
module pchk_parity_chk
    import pchk_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int NB = DATA_W / BYTE_W
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [NB-1:0]     par,
    output logic              err
);

    logic [NB-1:0] byte_bad;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        // even count of ones across byte plus its parity is a fault
        assign byte_bad[g] = ~(^{data[g*BYTE_W +: BYTE_W], par[g]});
    end

    assign err = valid & (|byte_bad);

endmodule

// File: rtl/pchk_addr_chk.sv
module pchk_addr_chk #(
    parameter int DEV_AW    = 4,
    parameter int DEV_LIMIT = 12
) (
    input  logic              req,
    input  logic [DEV_AW-1:0] addr,
    output logic              bad
);

    localparam logic [31:0] LIMIT32 = 32'(DEV_LIMIT);

    logic [31:0] addr32;

    assign addr32 = 32'(addr);
    assign bad    = req & (addr32 >= LIMIT32);

endmodule

// File: rtl/pchk_unit.sv
module pchk_unit
    import pchk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int IO_W      = 8,
    parameter int DEV_AW    = 4,
    parameter int DEV_LIMIT = 12,
    localparam int NB    = DATA_W / BYTE_W,
    localparam int BUS_W = DATA_W + NB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] st_wr_data,
    output logic [BUS_W-1:0]  st_wr_bus,
    input  logic              st_rd_valid,
    input  logic [BUS_W-1:0]  st_rd_bus,
    input  logic              io_in_valid,
    input  logic [IO_W-1:0]   io_in_data,
    input  logic              io_in_par,
    input  logic [IO_W-1:0]   io_out_src,
    output logic [IO_W-1:0]   io_out_pins_n,
    output logic              io_out_par_n,
    input  logic              dev_req,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic              halt_dis,
    input  logic              err_clr,
    output logic              halt,
    output logic              check_lamp,
    output logic              sts_st_par,
    output logic              sts_io_par,
    output logic              sts_bad_addr
);

    // Storage write path: data low, parity bits above
    logic [NB-1:0] wr_par;

    pchk_parity_gen #(.DATA_W(DATA_W)) u_wr_gen (
        .data (st_wr_data),
        .par  (wr_par)
    );

    assign st_wr_bus = {wr_par, st_wr_data};

    // Storage read check
    logic st_err;

    pchk_parity_chk #(.DATA_W(DATA_W)) u_rd_chk (
        .valid (st_rd_valid),
        .data  (st_rd_bus[DATA_W-1:0]),
        .par   (st_rd_bus[BUS_W-1:DATA_W]),
        .err   (st_err)
    );

    // Inbound I/O check (active-high pins)
    logic io_err;

    pchk_parity_chk #(.DATA_W(IO_W)) u_io_chk (
        .valid (io_in_valid),
        .data  (io_in_data),
        .par   (io_in_par),
        .err   (io_err)
    );

    // Outbound I/O: generate then invert for active-low pins
    logic io_out_par;

    pchk_parity_gen #(.DATA_W(IO_W)) u_io_gen (
        .data (io_out_src),
        .par  (io_out_par)
    );

    assign io_out_pins_n = ~io_out_src;
    assign io_out_par_n  = ~io_out_par;

    // Device address range
    logic addr_err;

    pchk_addr_chk #(.DEV_AW(DEV_AW), .DEV_LIMIT(DEV_LIMIT)) u_addr (
        .req  (dev_req),
        .addr (dev_addr),
        .bad  (addr_err)
    );

    // Fault latch, two-process
    fault_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (err_clr) begin
            flt_d = '0;
        end
        // a new fault takes priority over a clear in the same cycle
        if (st_err)   flt_d.st_par   = 1'b1;
        if (io_err)   flt_d.io_par   = 1'b1;
        if (addr_err) flt_d.bad_addr = 1'b1;
        if (st_err || io_err || addr_err) begin
            flt_d.lamp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign check_lamp   = flt_q.lamp;
    assign sts_st_par   = flt_q.st_par;
    assign sts_io_par   = flt_q.io_par;
    assign sts_bad_addr = flt_q.bad_addr;
    assign halt         = flt_q.lamp & ~halt_dis;

endmodule

// File: rtl/pchk_unit_chk.sv
module pchk_unit_chk #(
    parameter int DATA_W    = 16,
    parameter int IO_W      = 8,
    parameter int DEV_AW    = 4,
    parameter int DEV_LIMIT = 12,
    localparam int NB    = DATA_W / 8,
    localparam int BUS_W = DATA_W + NB
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  st_wr_bus,
    input logic              st_rd_valid,
    input logic [BUS_W-1:0]  st_rd_bus,
    input logic              io_in_valid,
    input logic [IO_W-1:0]   io_in_data,
    input logic              io_in_par,
    input logic [IO_W-1:0]   io_out_pins_n,
    input logic              io_out_par_n,
    input logic              dev_req,
    input logic [DEV_AW-1:0] dev_addr,
    input logic              halt_dis,
    input logic              err_clr,
    input logic              halt,
    input logic              check_lamp,
    input logic              sts_st_par,
    input logic              sts_io_par,
    input logic              sts_bad_addr
);

    logic wr_ok, rd_bad, io_bad, out_ok, addr_bad, any_evt;

    always_comb begin
        wr_ok  = 1'b1;
        rd_bad = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (!(^{st_wr_bus[i*8 +: 8], st_wr_bus[DATA_W+i]})) wr_ok = 1'b0;
            if (!(^{st_rd_bus[i*8 +: 8], st_rd_bus[DATA_W+i]})) rd_bad = 1'b1;
        end
        rd_bad   = rd_bad & st_rd_valid;
        io_bad   = io_in_valid & ~(^{io_in_data, io_in_par});
        out_ok   = ^{~io_out_pins_n, ~io_out_par_n};
        addr_bad = dev_req & (32'(dev_addr) >= 32'(DEV_LIMIT));
        any_evt  = rd_bad | io_bad | addr_bad;
    end

    assert_wr_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok);

    assert_rd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |=> sts_st_par);

    assert_io_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_bad |=> sts_io_par);

    assert_out_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok);

    assert_addr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_bad |=> sts_bad_addr);

    assert_lamp_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        check_lamp == (sts_st_par | sts_io_par | sts_bad_addr));

    assert_halt_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt == (check_lamp & ~halt_dis));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (check_lamp && !err_clr) |=> check_lamp);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !any_evt) |=> !check_lamp);

    assert_clear_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && any_evt) |=> check_lamp);

endmodule

bind pchk_unit pchk_unit_chk #(
    .DATA_W(DATA_W), .IO_W(IO_W), .DEV_AW(DEV_AW), .DEV_LIMIT(DEV_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_wr_bus(st_wr_bus),
    .st_rd_valid(st_rd_valid), .st_rd_bus(st_rd_bus),
    .io_in_valid(io_in_valid), .io_in_data(io_in_data), .io_in_par(io_in_par),
    .io_out_pins_n(io_out_pins_n), .io_out_par_n(io_out_par_n),
    .dev_req(dev_req), .dev_addr(dev_addr), .halt_dis(halt_dis),
    .err_clr(err_clr), .halt(halt), .check_lamp(check_lamp),
    .sts_st_par(sts_st_par), .sts_io_par(sts_io_par), .sts_bad_addr(sts_bad_addr)
);

// File: tb/pchk_unit_test.sv
module pchk_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] st_wr_data = '0;
    logic [17:0] st_wr_bus;
    logic        st_rd_valid = 1'b0;
    logic [17:0] st_rd_bus = '0;
    logic        io_in_valid = 1'b0;
    logic [7:0]  io_in_data = '0;
    logic        io_in_par = 1'b0;
    logic [7:0]  io_out_src = '0;
    logic [7:0]  io_out_pins_n;
    logic        io_out_par_n;
    logic        dev_req = 1'b0;
    logic [3:0]  dev_addr = '0;
    logic        halt_dis = 1'b0;
    logic        err_clr = 1'b0;
    logic        halt, check_lamp, sts_st_par, sts_io_par, sts_bad_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pchk_unit uut (
        .clk(clk), .rst_n(rst_n), .st_wr_data(st_wr_data), .st_wr_bus(st_wr_bus),
        .st_rd_valid(st_rd_valid), .st_rd_bus(st_rd_bus),
        .io_in_valid(io_in_valid), .io_in_data(io_in_data), .io_in_par(io_in_par),
        .io_out_src(io_out_src), .io_out_pins_n(io_out_pins_n),
        .io_out_par_n(io_out_par_n), .dev_req(dev_req), .dev_addr(dev_addr),
        .halt_dis(halt_dis), .err_clr(err_clr), .halt(halt),
        .check_lamp(check_lamp), .sts_st_par(sts_st_par),
        .sts_io_par(sts_io_par), .sts_bad_addr(sts_bad_addr)
    );

    function automatic logic ob(input logic [7:0] b);
        return ~^b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] flags();
        return {check_lamp, sts_bad_addr, sts_io_par, sts_st_par};
    endfunction

    task automatic clear();
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #7;
        @(negedge clk);
        chk("R11 reset flags", {28'd0, flags()}, 32'd0);
        chk("R11 reset halt", {31'd0, halt}, 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_write();
        logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h0001, 16'hA5C3};
        foreach (pats[i]) begin
            st_wr_data = pats[i];
            #1;
            chk("R1 write bus", {14'd0, st_wr_bus},
                {14'd0, ob(pats[i][15:8]), ob(pats[i][7:0]), pats[i]});
        end
    endtask

    task automatic t_read();
        // good word
        st_rd_bus = {ob(8'h3C), ob(8'h81), 16'h3C81};
        st_rd_valid = 1'b1;
        step();
        st_rd_valid = 1'b0;
        chk("R2 good read", {28'd0, flags()}, 32'd0);
        // bad high byte with strobe low
        st_rd_bus = {~ob(8'h3C), ob(8'h81), 16'h3C81};
        step();
        chk("R3 read strobe low", {28'd0, flags()}, 32'd0);
        // same word with strobe
        st_rd_valid = 1'b1;
        step();
        st_rd_valid = 1'b0;
        chk("R2 bad high byte", {28'd0, flags()}, 32'h9);
        chk("R8 halt on fault", {31'd0, halt}, 32'd1);
        step();
        chk("R9 sticky", {28'd0, flags()}, 32'h9);
        clear();
        chk("R9 cleared", {28'd0, flags()}, 32'd0);
        // all-zero word with zero parity
        st_rd_bus = '0;
        st_rd_valid = 1'b1;
        step();
        st_rd_valid = 1'b0;
        chk("R2 all-zero byte", {28'd0, flags()}, 32'h9);
        clear();
    endtask

    task automatic t_io();
        io_in_data = 8'h5A;
        io_in_par = ~ob(8'h5A);
        step();
        chk("R3 io strobe low", {28'd0, flags()}, 32'd0);
        io_in_par = ob(8'h5A);
        io_in_valid = 1'b1;
        step();
        chk("R4 io good", {28'd0, flags()}, 32'd0);
        io_in_par = ~ob(8'h5A);
        step();
        io_in_valid = 1'b0;
        chk("R4 io bad", {28'd0, flags()}, 32'hA);
        clear();
        foreach (io_out_src[i]) begin
            io_out_src = 8'h01 << i;
            #1;
            chk("R5 out pins", {24'd0, io_out_pins_n}, {24'd0, ~io_out_src});
            chk("R5 out parity", {31'd0, io_out_par_n}, {31'd0, ~ob(io_out_src)});
        end
        io_out_src = 8'h00;
        #1;
        chk("R5 out parity zero", {31'd0, io_out_par_n}, 32'd0);
    endtask

    task automatic t_addr();
        dev_req = 1'b0;
        dev_addr = 4'd15;
        step();
        chk("R6 idle request", {28'd0, flags()}, 32'd0);
        dev_req = 1'b1;
        dev_addr = 4'd11;
        step();
        chk("R6 below limit", {28'd0, flags()}, 32'd0);
        dev_addr = 4'd12;
        step();
        dev_req = 1'b0;
        chk("R6 at limit", {28'd0, flags()}, 32'hC);
        chk("R7 lamp", {31'd0, check_lamp}, 32'd1);
        clear();
    endtask

    task automatic t_mask();
        halt_dis = 1'b1;
        io_in_valid = 1'b1;
        io_in_data = 8'h00;
        io_in_par = 1'b0;
        step();
        io_in_valid = 1'b0;
        chk("R8 masked flags", {28'd0, flags()}, 32'hA);
        chk("R8 masked halt", {31'd0, halt}, 32'd0);
        halt_dis = 1'b0;
        #1;
        chk("R8 unmasked halt", {31'd0, halt}, 32'd1);
        clear();
        chk("R9 halt released", {31'd0, halt}, 32'd0);
    endtask

    task automatic t_race();
        err_clr = 1'b1;
        dev_req = 1'b1;
        dev_addr = 4'd14;
        step();
        err_clr = 1'b0;
        dev_req = 1'b0;
        chk("R10 fault beats clear", {28'd0, flags()}, 32'hC);
        // inject more, then reset clears all
        st_rd_bus = '0;
        st_rd_valid = 1'b1;
        step();
        st_rd_valid = 1'b0;
        chk("R7 multiple", {28'd0, flags()}, 32'hD);
        t_reset();
        chk("R11 after reset", {28'd0, flags()}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write();
                t_read();
                t_io();
                t_addr();
                t_mask();
                t_race();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule